// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block sequences a successive-approximation converter through its power-up and conversion steps. Software writes one control word that holds a power enable, a channel selector, a sync-mode bit and a start bit. The sequencer then counts the settling and conversion phases itself. Every count is in cycles of the serial bit clock, which is the block's own clock. The converter core lies outside the block. The sequencer tells the core when it is powered, which channel to use and when it is sampling. At the end of a conversion it latches the core's result.

The normal host pattern has two writes. The first write sets the channel. The second write repeats the same value with the start bit added. In sync mode the conversion waits for a rising edge on an external trigger pin. Completion sets a valid flag in the data word and raises a one-cycle interrupt request. An interrupt controller can detect that request on its edge.

Top module: `adc_seq`

## Requirements
- R1: After reset the data word is 0, and the interrupt, powered and sampling outputs are all 0.
- R2: A control write uses these fields: bit 0 is power enable, bit 1 is sync mode, bit 2 is start, and bits 5:3 are the channel. A write with enable 1 raises `corePowered` in the next cycle. A write with enable 0 lowers `corePowered` and `coreSampling` in the next cycle and aborts any pending conversion. An aborted conversion produces no valid flag and no interrupt. A start request is ignored while the block is powered down.
- R3: Reference warm-up lasts REF_CYC (60) cycles after the enable write. A start written on the edge REF_CYC cycles after that write is ignored. A start written one edge later is accepted.
- R4: The conversion phase begins SEL_CYC (51) cycles after the last change of the channel field, or later. If the channel has already settled, the conversion phase begins on the edge after the start write.
- R5: The conversion phase lasts CONV_CYC (102) cycles. The valid flag appears on the edge that ends it.
- R6: In sync mode the conversion begins only on a rising edge of `syncIn` sampled after the start was accepted. An edge that arrives during channel settling is remembered. A level that was already high when the start was accepted does not trigger a conversion.
- R7: The data word has the valid flag at bit 15 and the core result of the selected channel in bits 9:0. All other bits are 0. An accepted start clears the whole word.
- R8: `irqDone` is a single-cycle pulse in the same cycle that the valid flag rises.
- R9: A start written while a conversion is armed or running is ignored. The running conversion is neither restarted nor cleared.
- R10: Without sync mode, the valid flag is set no more than 256 cycles (two 128-bit frames) after the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 6 | Control word: enable, sync mode, start, channel |
| syncIn | input | 1 | External conversion trigger |
| coreResult | input | 10 | Result from the converter core |
| coreChan | output | 3 | Channel selected at the core input |
| corePowered | output | 1 | Converter and reference powered |
| coreSampling | output | 1 | Conversion phase active |
| dataWord | output | 16 | Valid flag and result |
| irqDone | output | 1 | Completion interrupt pulse |

## Verification
The conversion is driven from a table of write patterns:
- A start on a long-settled channel fixes the base latency.
- A channel change inside the start write, one cycle before it, and twenty cycles before it shows whether settling is counted from the last channel change or from the start.
- Sync triggers that come early, during settling, and late show that the trigger is latched and that the later of settling and trigger decides when conversion begins.
- A sync level that is already high when the start is accepted shows that the trigger is edge-detected.

Directed cases cover:
- a start on the exact last warm-up edge and on the edge after it;
- a start written during a conversion;
- a power-down during a conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Control word field positions
  localparam int EN_BIT    = 0;
  localparam int SYNC_BIT  = 1;
  localparam int START_BIT = 2;
  localparam int CHAN_LSB  = 3;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WARM,
    ST_READY,
    ST_ARM,
    ST_CONV
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic acceptStart;
    logic captureDone;
  } seqStrobe_t;

endpackage

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W  = 3,
  parameter int RES_W   = 10,
  parameter int DATA_W  = 16,
  parameter int SEL_CYC = 51,
  localparam int CTRL_W = CHAN_LSB + CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              syncIn,
  input  logic [RES_W-1:0]  coreResult,
  input  seqStrobe_t        strobe,
  output logic              nextEnable,
  output logic              startReq,
  output logic              selSettled,
  output logic              syncEn,
  output logic              syncEdge,
  output logic [CHAN_W-1:0] coreChan,
  output logic [DATA_W-1:0] dataWord,
  output logic              irqDone
);

  localparam int SEL_W = (SEL_CYC > 1) ? $clog2(SEL_CYC) : 1;
  localparam int PAD_W = DATA_W - 1 - RES_W;

  logic              enReg;
  logic              syncReg;
  logic [CHAN_W-1:0] chanReg;
  logic [SEL_W-1:0]  selCnt;
  logic              syncPrev;
  logic [DATA_W-1:0] dataReg;
  logic              irqReg;
  logic [CHAN_W-1:0] wrChan;

  assign wrChan     = ctrlWrData[CHAN_LSB +: CHAN_W];
  assign nextEnable = ctrlWrEn ? ctrlWrData[EN_BIT] : enReg;
  assign startReq   = ctrlWrEn & ctrlWrData[START_BIT];
  assign selSettled = (selCnt == SEL_W'(SEL_CYC - 1));
  assign syncEn     = syncReg;
  assign syncEdge   = syncIn & ~syncPrev;
  assign coreChan   = chanReg;
  assign dataWord   = dataReg;
  assign irqDone    = irqReg;

  // Control register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enReg   <= 1'b0;
      syncReg <= 1'b0;
      chanReg <= '0;
    end else if (ctrlWrEn) begin
      enReg   <= ctrlWrData[EN_BIT];
      syncReg <= ctrlWrData[SYNC_BIT];
      chanReg <= wrChan;
    end
  end

  // Input-select settling: counts from the last channel change
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selCnt <= '0;
    end else if (ctrlWrEn && (wrChan != chanReg)) begin
      selCnt <= '0;
    end else if (!enReg) begin
      selCnt <= '0;
    end else if (!selSettled) begin
      selCnt <= selCnt + 1'b1;
    end
  end

  // Trigger edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) syncPrev <= 1'b0;
    else        syncPrev <= syncIn;
  end

  // Result word and completion pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataReg <= '0;
      irqReg  <= 1'b0;
    end else begin
      irqReg <= strobe.captureDone;
      if (strobe.captureDone)      dataReg <= {1'b1, {PAD_W{1'b0}}, coreResult};
      else if (strobe.acceptStart) dataReg <= '0;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int REF_CYC  = 60,
  parameter int CONV_CYC = 102
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nextEnable,
  input  logic       startReq,
  input  logic       selSettled,
  input  logic       syncEn,
  input  logic       syncEdge,
  output seqStrobe_t strobe,
  output logic       powered,
  output logic       sampling
);

  localparam int MAX_CYC = (REF_CYC > CONV_CYC) ? REF_CYC : CONV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             syncSeen;
  logic             armGo;

  always_comb begin
    strobe.acceptStart = (state == ST_READY) && nextEnable && startReq;
    strobe.captureDone = (state == ST_CONV) && nextEnable &&
                         (cnt == CNT_W'(CONV_CYC - 1));
    armGo = (state == ST_ARM) && selSettled &&
            (!syncEn || syncEdge || syncSeen);
  end

  assign powered  = (state != ST_OFF);
  assign sampling = (state == ST_CONV);

  always_ff @(posedge clk) begin
    if (!rst_n || !nextEnable) begin
      state    <= ST_OFF;
      cnt      <= '0;
      syncSeen <= 1'b0;
    end else begin
      unique case (state)
        ST_OFF: begin
          state <= ST_WARM;
          cnt   <= '0;
        end
        ST_WARM: begin
          if (cnt == CNT_W'(REF_CYC - 1)) begin
            state <= ST_READY;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_READY: begin
          if (strobe.acceptStart) begin
            state    <= ST_ARM;
            syncSeen <= 1'b0;
          end
        end
        ST_ARM: begin
          if (armGo) begin
            state <= ST_CONV;
            cnt   <= '0;
          end else if (syncEdge) begin
            syncSeen <= 1'b1;
          end
        end
        ST_CONV: begin
          if (strobe.captureDone) state <= ST_READY;
          else                    cnt   <= cnt + 1'b1;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W   = 3,
  parameter int RES_W    = 10,
  parameter int DATA_W   = 16,
  parameter int REF_CYC  = 60,
  parameter int SEL_CYC  = 51,
  parameter int CONV_CYC = 102,
  localparam int CTRL_W  = CHAN_LSB + CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              syncIn,
  input  logic [RES_W-1:0]  coreResult,
  output logic [CHAN_W-1:0] coreChan,
  output logic              corePowered,
  output logic              coreSampling,
  output logic [DATA_W-1:0] dataWord,
  output logic              irqDone
);

  seqStrobe_t strobe;
  logic       nextEnable;
  logic       startReq;
  logic       selSettled;
  logic       syncEn;
  logic       syncEdge;

  adc_seq_dpath #(
    .CHAN_W (CHAN_W),
    .RES_W  (RES_W),
    .DATA_W (DATA_W),
    .SEL_CYC(SEL_CYC)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrlWrEn  (ctrlWrEn),
    .ctrlWrData(ctrlWrData),
    .syncIn    (syncIn),
    .coreResult(coreResult),
    .strobe    (strobe),
    .nextEnable(nextEnable),
    .startReq  (startReq),
    .selSettled(selSettled),
    .syncEn    (syncEn),
    .syncEdge  (syncEdge),
    .coreChan  (coreChan),
    .dataWord  (dataWord),
    .irqDone   (irqDone)
  );

  adc_seq_ctrl #(
    .REF_CYC (REF_CYC),
    .CONV_CYC(CONV_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .nextEnable(nextEnable),
    .startReq  (startReq),
    .selSettled(selSettled),
    .syncEn    (syncEn),
    .syncEdge  (syncEdge),
    .strobe    (strobe),
    .powered   (corePowered),
    .sampling  (coreSampling)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CONV_CYC = 102
) (
  input logic clk,
  input logic rst_n,
  input logic wrEn,
  input logic wrEnable,
  input logic powered,
  input logic sampling,
  input logic validFlag,
  input logic irq
);

  localparam int RUN_W = $clog2(CONV_CYC + 2);

  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rst_n)        runLen <= '0;
    else if (sampling) runLen <= runLen + 1'b1;
    else               runLen <= '0;
  end

  // R8: the completion pulse lasts one cycle
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7/R8: the valid flag rises together with the interrupt
  a_r7_valid_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(validFlag) |-> irq);

  a_r8_irq_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> validFlag);

  // R5: completion follows exactly CONV_CYC sampling cycles
  a_r5_conv_len: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (runLen == RUN_W'(CONV_CYC)));

  // R2: a power-down write leaves the core unpowered and idle
  a_r2_powerdown: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrEnable) |=> (!powered && !sampling));

  a_r2_no_sample_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !powered |-> !sampling);

endmodule

bind adc_seq adc_seq_chk #(.CONV_CYC(CONV_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wrEn     (ctrlWrEn),
  .wrEnable (ctrlWrData[0]),
  .powered  (corePowered),
  .sampling (coreSampling),
  .validFlag(dataWord[DATA_W-1]),
  .irq      (irqDone)
);

// File: tb/adc_seq_bench.sv
module adc_seq_bench;

  localparam int REF  = 60;
  localparam int WAIT_MAX = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [5:0]  ctrlWrData = '0;
  logic        syncIn = 1'b0;
  logic [9:0]  coreResult;
  logic [2:0]  coreChan;
  logic        corePowered;
  logic        coreSampling;
  logic [15:0] dataWord;
  logic        irqDone;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  adc_seq u_adc_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrlWrEn    (ctrlWrEn),
    .ctrlWrData  (ctrlWrData),
    .syncIn      (syncIn),
    .coreResult  (coreResult),
    .coreChan    (coreChan),
    .corePowered (corePowered),
    .coreSampling(coreSampling),
    .dataWord    (dataWord),
    .irqDone     (irqDone)
  );

  // Behavioural converter core: a fixed level per channel
  function automatic logic [9:0] lvl(input logic [2:0] ch);
    return 10'h0A3 + 10'(ch) * 10'd97;
  endfunction
  assign coreResult = lvl(coreChan);

  function automatic int expWord(input logic [2:0] ch);
    return int'({1'b1, 5'b0, lvl(ch)});
  endfunction

  typedef struct packed {
    logic [2:0] chan;
    logic       pre;
    logic [7:0] gap;
    logic       sync;
    logic [7:0] dly;
    logic [8:0] lat;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 1'b0, 8'd0,  1'b0, 8'd0,  9'd103},  // settled channel
    '{3'd3, 1'b0, 8'd0,  1'b0, 8'd0,  9'd153},  // change inside start write
    '{3'd6, 1'b1, 8'd0,  1'b0, 8'd0,  9'd152},  // change one cycle ahead
    '{3'd2, 1'b1, 8'd20, 1'b0, 8'd0,  9'd132},  // change 21 cycles ahead
    '{3'd7, 1'b1, 8'd60, 1'b0, 8'd0,  9'd103},  // fully settled ahead
    '{3'd7, 1'b0, 8'd0,  1'b1, 8'd10, 9'd113},  // sync after settle
    '{3'd1, 1'b0, 8'd0,  1'b1, 8'd5,  9'd153},  // sync during settle
    '{3'd4, 1'b1, 8'd0,  1'b1, 8'd80, 9'd183}   // sync late
  };

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; sampled at the next posedge
  task automatic wr(input logic en, input logic sy, input logic st,
                    input logic [2:0] ch);
    ctrlWrEn   = 1'b1;
    ctrlWrData = {ch, st, sy, en};
    @(negedge clk);
    ctrlWrEn   = 1'b0;
  endtask

  task automatic waitValid(input logic useSync, input int dly, output int n);
    n = 0;
    while (!dataWord[15] && n < WAIT_MAX) begin
      if (useSync && n == dly) syncIn = 1'b1;
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int n;
    int irqSeen;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 dataWord", int'(dataWord), 0);
    chk("R1 irqDone", int'(irqDone), 0);
    chk("R1 corePowered", int'(corePowered), 0);
    chk("R1 coreSampling", int'(coreSampling), 0);

    // R2 start while unpowered is ignored
    wr(1'b0, 1'b0, 1'b1, 3'd2);
    waitValid(1'b0, 0, n);
    chk("R2 start while off valid", int'(dataWord[15]), 0);
    chk("R2 start while off powered", int'(corePowered), 0);

    // R3 warm-up boundary
    wr(1'b1, 1'b0, 1'b0, 3'd0);
    chk("R2 powered after enable", int'(corePowered), 1);
    repeat (REF - 1) @(negedge clk);
    wr(1'b1, 1'b0, 1'b1, 3'd0);
    waitValid(1'b0, 0, n);
    chk("R3 start on last warm edge ignored", n, WAIT_MAX);
    wr(1'b0, 1'b0, 1'b0, 3'd0);
    chk("R2 powered after disable", int'(corePowered), 0);
    repeat (3) @(negedge clk);
    wr(1'b1, 1'b0, 1'b0, 3'd0);
    repeat (REF) @(negedge clk);
    wr(1'b1, 1'b0, 1'b1, 3'd0);
    waitValid(1'b0, 0, n);
    chk("R3 start after warm-up latency", n, 103);
    repeat (4) @(negedge clk);

    // Main function: table of write patterns (R4 R5 R6 R7 R8 R10)
    foreach (VECS[i]) begin
      if (VECS[i].pre) begin
        wr(1'b1, 1'b0, 1'b0, VECS[i].chan);
        repeat (int'(VECS[i].gap)) @(negedge clk);
      end
      wr(1'b1, VECS[i].sync, 1'b1, VECS[i].chan);
      chk($sformatf("R7 word cleared on accept v%0d", i), int'(dataWord), 0);
      waitValid(VECS[i].sync, int'(VECS[i].dly), n);
      chk($sformatf("R4/R5/R6 latency v%0d", i), n, int'(VECS[i].lat));
      chk($sformatf("R7 data word v%0d", i), int'(dataWord), expWord(VECS[i].chan));
      chk($sformatf("R8 irq with valid v%0d", i), int'(irqDone), 1);
      if (!VECS[i].sync)
        chk($sformatf("R10 within two frames v%0d", i), int'(n <= 256), 1);
      @(negedge clk);
      chk($sformatf("R8 irq one cycle v%0d", i), int'(irqDone), 0);
      syncIn = 1'b0;
      repeat (5) @(negedge clk);
    end

    // R9 start during conversion is ignored
    wr(1'b1, 1'b0, 1'b0, 3'd1);
    repeat (60) @(negedge clk);
    wr(1'b1, 1'b0, 1'b1, 3'd1);
    repeat (29) @(negedge clk);
    wr(1'b1, 1'b0, 1'b1, 3'd1);
    chk("R9 busy start keeps word clear", int'(dataWord), 0);
    waitValid(1'b0, 0, n);
    chk("R9 no restart latency", n, 73);
    chk("R9 data word", int'(dataWord), expWord(3'd1));
    repeat (3) @(negedge clk);

    // R2 power-down aborts a running conversion
    wr(1'b1, 1'b0, 1'b1, 3'd1);
    repeat (20) @(negedge clk);
    wr(1'b0, 1'b0, 1'b0, 3'd1);
    chk("R2 abort powered", int'(corePowered), 0);
    chk("R2 abort sampling", int'(coreSampling), 0);
    irqSeen = 0;
    for (int c = 0; c < 300; c++) begin
      if (irqDone || dataWord[15]) irqSeen = 1;
      @(negedge clk);
    end
    chk("R2 abort no completion", irqSeen, 0);
    chk("R2 abort word", int'(dataWord), 0);

    // R6 a level already high is not a trigger
    wr(1'b1, 1'b0, 1'b0, 3'd1);
    repeat (70) @(negedge clk);
    syncIn = 1'b1;
    repeat (3) @(negedge clk);
    wr(1'b1, 1'b1, 1'b1, 3'd1);
    waitValid(1'b0, 0, n);
    chk("R6 held level no trigger", n, WAIT_MAX);
    syncIn = 1'b0;
    @(negedge clk);
    syncIn = 1'b1;
    waitValid(1'b0, 0, n);
    chk("R6 fresh edge latency", n, 103);
    chk("R6 data word", int'(dataWord), expWord(3'd1));
    syncIn = 1'b0;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule